// File: doc/BRIEF.md
# Reference Switchover Phase Build-Out Controller

This block sits in a digital clock path and decides what happens to phase when the input reference changes. When a switch is requested, it looks up the selection priority stored for the incoming reference and compares it with a programmable phase-master threshold. A lower priority value means a more important reference.

If the new reference ranks as a phase master, the stored phase offset is cleared and the output realigns to the new reference. Otherwise the block does a build-out. It latches the phase error present in the switch cycle as an offset, and from then on it subtracts that offset from the incoming error. The output therefore sees no phase step.

A small register port holds the per-reference priority table and the threshold. Priority arbitration and loop filtering are done by other blocks.

Top module: `refswitch_buildout`

## Requirements
- R1: After reset the phase offset is 0, `done` is 0 and `realigned` is 0. The threshold reads 0, and the priority entry of reference i reads i.
- R2: A write with `reg_addr` 0 to NREF-1 stores `reg_wdata` as that reference's priority. A write with `reg_addr` equal to NREF stores the threshold. Reads are combinational and return the stored value. Any other address stores nothing and reads 0.
- R3: A reference is a phase master only when its priority is strictly less than the threshold.
- R4: A switch to a reference that is not a phase master loads `phase_err`, as sampled in the switch cycle, into the offset. The new offset is visible from the next cycle.
- R5: A switch to a phase master loads 0 into the offset.
- R6: `phase_out` always equals `phase_err` minus the current offset, modulo 2^PH_W.
- R7: `done` is high for exactly the cycle after each cycle in which `switch_req` is high.
- R8: `realigned` becomes 1 after a switch to a phase master and 0 after a build-out. It holds that value until the next switch.
- R9: Without a switch request the offset does not change.
- R10: With the threshold at 0, no reference is a phase master, even one whose priority is 0.
- R11: A register write in the same cycle as a switch does not affect that switch's decision. The decision uses the values stored before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| switch_req | input | 1 | A reference switch happens in this cycle |
| new_ref | input | IDX_W (2) | Index of the incoming reference |
| phase_err | input | PH_W (16) | Signed phase error from the detector |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (3) | Register address: 0..NREF-1 priorities, NREF threshold |
| reg_wdata | input | PRIO_W (4) | Register write data |
| reg_rdata | output | PRIO_W (4) | Register read data, combinational |
| phase_offset | output | PH_W (16) | Current signed offset |
| phase_out | output | PH_W (16) | Phase error with the offset removed |
| done | output | 1 | One-cycle pulse after each decision |
| realigned | output | 1 | 1 if the last switch was a realignment, 0 if a build-out |

## Verification
The offset, `done` and `realigned` all come from the single register stage that follows the switch cycle. All three are due one clock edge after `switch_req` is seen. `phase_out` and `reg_rdata` are combinational and follow their inputs in the same cycle.

The driver applies inputs just after the falling edge. Each switch it issues pushes the expected offset and status into a queue. The monitor samples shortly after every rising edge, pops one entry whenever `done` is high, and compares the outputs. Register reads are checked a short delay after the address is driven.

// File: rtl/refswitch_buildout.sv
module refswitch_buildout #(
  parameter int NREF   = 4,
  parameter int PRIO_W = 4,
  parameter int PH_W   = 16,
  localparam int IDX_W  = (NREF > 1) ? $clog2(NREF) : 1,
  localparam int ADDR_W = $clog2(NREF + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   switch_req,
  input  logic [IDX_W-1:0]       new_ref,
  input  logic signed [PH_W-1:0] phase_err,
  input  logic                   reg_wr,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [PRIO_W-1:0]      reg_wdata,
  output logic [PRIO_W-1:0]      reg_rdata,
  output logic signed [PH_W-1:0] phase_offset,
  output logic signed [PH_W-1:0] phase_out,
  output logic                   done,
  output logic                   realigned
);

  logic [PRIO_W-1:0] prio_q [NREF];
  logic [PRIO_W-1:0] thresh_q;
  logic [PRIO_W-1:0] new_prio;
  logic              ref_ok;
  logic              is_master;

  assign ref_ok    = 32'(new_ref) < NREF;
  assign new_prio  = ref_ok ? prio_q[new_ref] : '1;
  assign is_master = ref_ok && (new_prio < thresh_q);
  assign phase_out = phase_err - phase_offset;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREF; i++) prio_q[i] <= PRIO_W'(i);
      thresh_q <= '0;
    end else if (reg_wr) begin
      if (32'(reg_addr) < NREF) prio_q[reg_addr[IDX_W-1:0]] <= reg_wdata;
      else if (32'(reg_addr) == NREF) thresh_q <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (32'(reg_addr) < NREF) reg_rdata = prio_q[reg_addr[IDX_W-1:0]];
    else if (32'(reg_addr) == NREF) reg_rdata = thresh_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_offset <= '0;
      done         <= 1'b0;
      realigned    <= 1'b0;
    end else begin
      done <= switch_req;
      if (switch_req) begin
        phase_offset <= is_master ? '0 : phase_err;
        realigned    <= is_master;
      end
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    switch_req |=> done);
  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !switch_req |=> !done);
  // R9
  offset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !switch_req |=> $stable(phase_offset) && $stable(realigned));
  // R5
  realign_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && realigned) |-> phase_offset == '0);
  // R4
  buildout_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !realigned) |-> phase_offset == $past(phase_err));

endmodule

// File: tb/refswitch_buildout_tb_top.sv
`timescale 1ns/100ps
module refswitch_buildout_tb_top;
  logic clk = 0, rst_n = 0, switch_req = 0, reg_wr = 0;
  logic [1:0] new_ref = 0;
  logic signed [15:0] phase_err = 0;
  logic [2:0] reg_addr = 0;
  logic [3:0] reg_wdata = 0;
  logic [3:0] reg_rdata;
  logic signed [15:0] phase_offset, phase_out;
  logic done, realigned;

  int checks = 0, errors = 0;
  logic [3:0] prio_m [4];
  logic [3:0] thr_m;
  logic signed [15:0] q_off [$];
  bit q_rl [$];
  logic signed [15:0] cur_off;

  always #2.5 clk = ~clk;

  refswitch_buildout dut_i (.clk, .rst_n, .switch_req, .new_ref, .phase_err,
    .reg_wr, .reg_addr, .reg_wdata, .reg_rdata, .phase_offset, .phase_out,
    .done, .realigned);

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [3:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    if (a < 4) prio_m[a[1:0]] = d; else if (a == 4) thr_m = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, logic [3:0] exp, string tag);
    @(negedge clk);
    reg_addr = a;
    #1 chk(tag, reg_rdata, exp);
  endtask

  task automatic push(logic [1:0] r, logic signed [15:0] ph);
    bit m;
    m = prio_m[r] < thr_m;
    q_rl.push_back(m);
    q_off.push_back(m ? 16'sd0 : ph);
  endtask

  task automatic sw(logic [1:0] r, logic signed [15:0] ph);
    @(negedge clk);
    switch_req = 1; new_ref = r; phase_err = ph;
    push(r, ph);
    @(negedge clk);
    switch_req = 0;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && done) begin
        if (q_off.size() == 0) chk("R7 unexpected done", 1, 0);
        else begin
          cur_off = q_off.pop_front();
          chk("R4/R5 offset", phase_offset, cur_off);
          chk("R8 realigned", realigned, q_rl.pop_front());
          chk("R6 phase_out", phase_out, 16'(phase_err - cur_off));
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 4; i++) prio_m[i] = 4'(i);
    thr_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 offset", phase_offset, 0);
    chk("R1 done", done, 0);
    chk("R1 realigned", realigned, 0);
    rd(4, 0, "R1 threshold");
    for (int i = 0; i < 4; i++) rd(3'(i), 4'(i), "R1 priority");

    sw(2, 16'sd100);                  // R4 build-out, R10 thr 0
    for (int i = 0; i < 3; i++) begin // R9 hold, R6 subtraction
      @(negedge clk); phase_err = 16'(i * 7 - 9);
      #1 chk("R9 offset held", phase_offset, 100);
      chk("R6 phase_out", phase_out, 16'(phase_err - 16'sd100));
    end

    wr(4, 3); rd(4, 3, "R2 threshold");
    sw(2, 16'sd55);                   // R3/R5: 2<3 realign
    sw(3, -16'sd50);                  // R3: 3<3 false -> build-out

    wr(0, 0); wr(4, 0);               // R10: priority 0, threshold 0
    rd(0, 0, "R2 priority 0");
    sw(0, 16'sd77);

    wr(5, 7); rd(5, 0, "R2 unmapped addr");
    rd(4, 0, "R2 threshold unchanged");
    wr(7, 9); rd(0, 0, "R2 priority unchanged");

    wr(4, 1); wr(1, 1);
    @(negedge clk);                   // R11 write in switch cycle
    switch_req = 1; new_ref = 1; phase_err = 16'sd300;
    push(1, 16'sd300);
    reg_wr = 1; reg_addr = 1; reg_wdata = 0; prio_m[1] = 0;
    @(negedge clk);
    switch_req = 0; reg_wr = 0;
    sw(1, 16'sd400);                  // R11 now master -> realign

    @(negedge clk);                   // R7 back-to-back
    switch_req = 1; new_ref = 2; phase_err = 16'sd11; push(2, 16'sd11);
    @(negedge clk);
    new_ref = 1; phase_err = 16'sd22; push(1, 16'sd22);
    @(negedge clk);
    switch_req = 0;

    sw(3, 16'sd1000);                 // R6 wraparound
    @(negedge clk); phase_err = -16'sd32768;
    #1 chk("R6 wrap", phase_out, 16'(-16'sd32768 - 16'sd1000));

    repeat (4) @(negedge clk);
    chk("R7 all decisions seen", q_off.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule